// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Flags

This block holds the status flags and the single interrupt request of a byte-oriented I2C/SMBus controller. A separate bit-level engine reports what happens on the wire through one-cycle strobes. The strobes cover the ninth clock of each byte together with the byte just shifted, the loading of a received byte, the handoff of the transmit byte to the shifter, and the result of a PEC comparison. The CPU side supplies write strobes for the status, control and transmit-data registers, and a read strobe for the receive-data register.

The block keeps these state bits:
- the receive-ready and transmit-ready interrupt flags;
- the receive-full and transmit-empty buffer flags;
- the slave address-match flag, with the direction bit of the call that matched;
- the last acknowledge bit seen;
- a CRC error flag that reset does not touch;
- the master direction control bit.

It also stores the receive and transmit data bytes. The CPU clears the interrupt flags by writing zero to them. A flag that the CPU is clearing sets anyway if its event arrives in the same cycle.

Top module: `i2c_sf_top`

## Requirements
- R1: After reset `status_o` reads 0x0A in its reset-defined bits, with bit 2 excluded. The bit layout is: bit 7 receive interrupt flag, bit 6 transmit interrupt flag, bit 5 address match, bit 4 slave direction, bit 3 received acknowledge level (1 = no acknowledge), bit 2 CRC error, bit 1 transmit buffer empty, bit 0 receive buffer full. Also after reset, `irq_o` and `mrw_o` are 0.
- R2: When `rx_load_i` pulses while bit 0 is clear, `rx_data_i` is captured into `rx_data_o` on that edge, and bits 7 and 0 of `status_o` both become 1.
- R3: While bit 0 is set, a `rx_load_i` pulse neither changes `rx_data_o` nor sets bit 7. A `drr_rd_i` pulse clears bit 0, and after that the next load is accepted.
- R4: A `dtr_wr_i` pulse stores `wdata_i` in `tx_data_o` and clears bit 1. A `tx_xfer_i` pulse sets both bit 6 and bit 1.
- R5: An `sr_wr_i` pulse clears bit 7 or bit 6 where the matching `wdata_i` bit is 0. Writing 1 to those bits changes nothing, and `sr_wr_i` never alters bits 5 to 0.
- R6: When a set event for bit 7 or bit 6 lands in the same cycle as a status write of 0 to that bit, the bit ends up set.
- R7: While `en_i` is 0, bits 7 and 6 are held at 0, even if their set events arrive.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and bit 7 or bit 6 is 1.
- R9: On a `ninth_clk_i` pulse with `byte_is_addr_i` set, bit 5 takes the result of the address comparison. On a match, bit 4 takes `shift_byte_i[0]`; the address itself is `shift_byte_i[7:1]`. A ninth clock on a data byte clears bit 5, unless `slave_tx_i` is set, in which case bit 5 is kept.
- R10: With `ext_en_i` set, an address whose upper 7−EXT_BITS bits equal those of `own_addr_i` also matches (EXT_BITS = 3 by default). With `ext_en_i` clear, only an exact match counts.
- R11: A `pec_done_i` pulse sets bit 2 when `pec_ok_i` is 0 and clears it when `pec_ok_i` is 1. Reset leaves bit 2 unchanged.
- R12: A `ctrl_wr_i` pulse loads `wdata_i[0]` into `mrw_o` (1 = master receive, 0 = master transmit). Reset clears `mrw_o`.
- R13: Every `ninth_clk_i` pulse loads `ack_i` into bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable |
| irq_en_i | input | 1 | Interrupt enable |
| ext_en_i | input | 1 | Extended address matching enable |
| own_addr_i | input | 7 | Programmed slave address |
| ninth_clk_i | input | 1 | Ninth clock of a byte strobe |
| byte_is_addr_i | input | 1 | Current byte is a calling address |
| slave_tx_i | input | 1 | Current byte is a slave transmit |
| shift_byte_i | input | 8 | Byte in the shifter at the ninth clock |
| ack_i | input | 1 | Acknowledge level at the ninth clock |
| rx_load_i | input | 1 | Received byte ready strobe |
| rx_data_i | input | 8 | Received byte |
| tx_xfer_i | input | 1 | Transmit byte moved to the shifter |
| pec_done_i | input | 1 | PEC byte checked strobe |
| pec_ok_i | input | 1 | PEC matched |
| sr_wr_i | input | 1 | CPU write to the status register |
| ctrl_wr_i | input | 1 | CPU write to the direction control bit |
| dtr_wr_i | input | 1 | CPU write to transmit data |
| drr_rd_i | input | 1 | CPU read of receive data |
| wdata_i | input | 8 | CPU write data |
| status_o | output | 8 | Status register |
| rx_data_o | output | 8 | Receive data register |
| tx_data_o | output | 8 | Transmit data register |
| mrw_o | output | 1 | Master direction bit |
| irq_o | output | 1 | Interrupt request |

## Verification
Several rules are checked by the assertions on every cycle:
- a load arriving while the receive buffer is full leaves the receive data unchanged;
- a low enable clears both interrupt flags;
- a set event beats a clear written in the same cycle;
- a slave-transmit ninth clock keeps the match flag;
- a failing PEC sets the CRC flag;
- the interrupt request never rises while interrupts are disabled.

Other behaviour can only be shown by the bench's scenarios, because it depends on history:
- the exact reset value;
- the extended-address window against the exact match;
- the direction bit captured from a matching call;
- the CRC flag surviving a reset;
- write-1 and read-only writes leaving the flags alone.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 7;
  localparam int unsigned B_RXIF = 7;
  localparam int unsigned B_TXIF = 6;
  localparam int unsigned B_MAT  = 5;
  localparam int unsigned B_SRW  = 4;
  localparam int unsigned B_RXAK = 3;
  localparam int unsigned B_CRC  = 2;
  localparam int unsigned B_TXBE = 1;
  localparam int unsigned B_RXBF = 0;

  typedef struct packed {
    logic rxif;
    logic txif;
    logic mat;
    logic srw;
    logic rxak;
    logic crc;
    logic txbe;
    logic rxbf;
  } stat_t;
endpackage

// File: rtl/i2c_sf_rx.sv
module i2c_sf_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          flag_o,
  output logic          full_o
);
  logic accept;
  assign accept = load_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (accept) begin
        data_o <= data_i;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
    end
  end

  // enable low overrides; set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (!en_i)    flag_o <= 1'b0;
    else if (accept)   flag_o <= 1'b1;
    else if (clr_i)    flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_sf_tx.sv
module i2c_sf_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          flag_o,
  output logic          empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (wr_i) data_o <= wdata_i;
      if (xfer_i)    empty_o <= 1'b1;
      else if (wr_i) empty_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (!en_i)  flag_o <= 1'b0;
    else if (xfer_i) flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_sf_addr.sv
module i2c_sf_addr #(
  parameter int unsigned AW       = 7,
  parameter int unsigned EXT_BITS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_en_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          ninth_i,
  input  logic          is_addr_i,
  input  logic          slave_tx_i,
  input  logic [AW:0]   byte_i,
  input  logic          ack_i,
  input  logic          pec_done_i,
  input  logic          pec_ok_i,
  output logic          mat_o,
  output logic          srw_o,
  output logic          rxak_o,
  output logic          crc_o
);
  localparam int unsigned HI = AW - EXT_BITS;

  logic [AW-1:0] call_addr;
  logic          hit_exact, hit_ext, hit;

  assign call_addr = byte_i[AW:1];
  assign hit_exact = (call_addr == own_addr_i);

  generate
    if (HI > 0) begin : g_ext
      assign hit_ext = (call_addr[AW-1:EXT_BITS] == own_addr_i[AW-1:EXT_BITS]);
    end else begin : g_all
      assign hit_ext = 1'b1;
    end
  endgenerate

  assign hit = hit_exact || (ext_en_i && hit_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mat_o  <= 1'b0;
      srw_o  <= 1'b0;
      rxak_o <= 1'b1;
    end else if (ninth_i) begin
      rxak_o <= ack_i;
      if (is_addr_i) begin
        mat_o <= hit;
        if (hit) srw_o <= byte_i[0];
      end else if (!slave_tx_i) begin
        mat_o <= 1'b0;
      end
    end
  end

  // intentionally outside reset
  always_ff @(posedge clk_i) begin
    if (pec_done_i) crc_o <= !pec_ok_i;
  end
endmodule

// File: rtl/i2c_sf_top.sv
module i2c_sf_top
  import i2c_sf_pkg::*;
#(
  parameter int unsigned EXT_BITS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          irq_en_i,
  input  logic          ext_en_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          ninth_clk_i,
  input  logic          byte_is_addr_i,
  input  logic          slave_tx_i,
  input  logic [DW-1:0] shift_byte_i,
  input  logic          ack_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          tx_xfer_i,
  input  logic          pec_done_i,
  input  logic          pec_ok_i,
  input  logic          sr_wr_i,
  input  logic          ctrl_wr_i,
  input  logic          dtr_wr_i,
  input  logic          drr_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] rx_data_o,
  output logic [DW-1:0] tx_data_o,
  output logic          mrw_o,
  output logic          irq_o
);
  stat_t st;
  logic  clr_rx, clr_tx;

  assign clr_rx = sr_wr_i && !wdata_i[B_RXIF];
  assign clr_tx = sr_wr_i && !wdata_i[B_TXIF];

  i2c_sf_rx #(.DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (rx_load_i),
    .data_i (rx_data_i),
    .rd_i   (drr_rd_i),
    .clr_i  (clr_rx),
    .data_o (rx_data_o),
    .flag_o (st.rxif),
    .full_o (st.rxbf)
  );

  i2c_sf_tx #(.DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .wr_i    (dtr_wr_i),
    .wdata_i (wdata_i),
    .xfer_i  (tx_xfer_i),
    .clr_i   (clr_tx),
    .data_o  (tx_data_o),
    .flag_o  (st.txif),
    .empty_o (st.txbe)
  );

  i2c_sf_addr #(.AW(AW), .EXT_BITS(EXT_BITS)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_en_i   (ext_en_i),
    .own_addr_i (own_addr_i),
    .ninth_i    (ninth_clk_i),
    .is_addr_i  (byte_is_addr_i),
    .slave_tx_i (slave_tx_i),
    .byte_i     (shift_byte_i),
    .ack_i      (ack_i),
    .pec_done_i (pec_done_i),
    .pec_ok_i   (pec_ok_i),
    .mat_o      (st.mat),
    .srw_o      (st.srw),
    .rxak_o     (st.rxak),
    .crc_o      (st.crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mrw_o <= 1'b0;
    else if (ctrl_wr_i) mrw_o <= wdata_i[0];
  end

  assign status_o = st;
  assign irq_o    = irq_en_i && (st.rxif || st.txif);
endmodule

// File: rtl/i2c_sf_chk.sv
module i2c_sf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       irq_en_i,
  input logic       ninth_clk_i,
  input logic       byte_is_addr_i,
  input logic       slave_tx_i,
  input logic       rx_load_i,
  input logic       tx_xfer_i,
  input logic       pec_done_i,
  input logic       pec_ok_i,
  input logic       sr_wr_i,
  input logic       dtr_wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] status_o,
  input logic [7:0] rx_data_o,
  input logic       irq_o
);
  // R3
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && status_o[0]) |=> $stable(rx_data_o));

  // R7
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!status_o[7] && !status_o[6]));

  // R6
  tx_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_xfer_i && sr_wr_i && !wdata_i[6]) |=> status_o[6]);

  // R4
  txbe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtr_wr_i && !tx_xfer_i) |=> !status_o[1]);

  // R9
  mat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ninth_clk_i && !byte_is_addr_i && slave_tx_i && status_o[5]) |=> status_o[5]);

  // R11
  crc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pec_done_i && !pec_ok_i) |=> status_o[2]);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

bind i2c_sf_top i2c_sf_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .irq_en_i       (irq_en_i),
  .ninth_clk_i    (ninth_clk_i),
  .byte_is_addr_i (byte_is_addr_i),
  .slave_tx_i     (slave_tx_i),
  .rx_load_i      (rx_load_i),
  .tx_xfer_i      (tx_xfer_i),
  .pec_done_i     (pec_done_i),
  .pec_ok_i       (pec_ok_i),
  .sr_wr_i        (sr_wr_i),
  .dtr_wr_i       (dtr_wr_i),
  .wdata_i        (wdata_i),
  .status_o       (status_o),
  .rx_data_o      (rx_data_o),
  .irq_o          (irq_o)
);

// File: tb/tb_i2c_sf_top.sv
`timescale 1ns/1ps
module tb_i2c_sf_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1, irq_en_i = 1'b0, ext_en_i = 1'b0;
  logic [6:0] own_addr_i = 7'h50;
  logic       ninth_clk_i = 0, byte_is_addr_i = 0, slave_tx_i = 0;
  logic [7:0] shift_byte_i = '0;
  logic       ack_i = 1'b1;
  logic       rx_load_i = 0;
  logic [7:0] rx_data_i = '0;
  logic       tx_xfer_i = 0, pec_done_i = 0, pec_ok_i = 0;
  logic       sr_wr_i = 0, ctrl_wr_i = 0, dtr_wr_i = 0, drr_rd_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] status_o, rx_data_o, tx_data_o;
  logic       mrw_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  i2c_sf_top dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ninth_clk_i = 0; byte_is_addr_i = 0; slave_tx_i = 0; rx_load_i = 0;
    tx_xfer_i = 0; pec_done_i = 0; sr_wr_i = 0; ctrl_wr_i = 0;
    dtr_wr_i = 0; drr_rd_i = 0;
  endtask

  // inputs are set after a negedge; the next negedge ends the pulse
  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o & 8'hFB, 8'h0A);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    chk("R1 mrw", {7'b0, mrw_o}, 8'h00);
  endtask

  task automatic t_rx();
    rx_load_i = 1; rx_data_i = 8'hA5; step();
    chk("R2 data", rx_data_o, 8'hA5);
    chk("R2 flags", status_o & 8'h81, 8'h81);
    sr_wr_i = 1; wdata_i = 8'h7F; step();
    chk("R5 clr rxif", status_o & 8'h81, 8'h01);
    rx_load_i = 1; rx_data_i = 8'h3C; step();
    chk("R3 hold data", rx_data_o, 8'hA5);
    chk("R3 no rxif", status_o & 8'h80, 8'h00);
    drr_rd_i = 1; step();
    chk("R3 read clr", status_o & 8'h01, 8'h00);
    rx_load_i = 1; rx_data_i = 8'h3C; step();
    chk("R3 reload", rx_data_o, 8'h3C);
    drr_rd_i = 1; step();
  endtask

  task automatic t_tx();
    dtr_wr_i = 1; wdata_i = 8'h96; step();
    chk("R4 data", tx_data_o, 8'h96);
    chk("R4 txbe clr", status_o & 8'h02, 8'h00);
    tx_xfer_i = 1; step();
    chk("R4 txif txbe", status_o & 8'h42, 8'h42);
    chk("R8 irq off", {7'b0, irq_o}, 8'h00);
    irq_en_i = 1; #1;
    chk("R8 irq on", {7'b0, irq_o}, 8'h01);
    sr_wr_i = 1; wdata_i = 8'hFF; step();
    chk("R5 write1", status_o & 8'h40, 8'h40);
    sr_wr_i = 1; wdata_i = 8'h00; step();
    chk("R5 clr txif", status_o & 8'hC0, 8'h00);
    chk("R5 ro bits", status_o & 8'h02, 8'h02);
    chk("R8 irq drop", {7'b0, irq_o}, 8'h00);
    tx_xfer_i = 1; sr_wr_i = 1; wdata_i = 8'h00; step();
    chk("R6 set wins", status_o & 8'h40, 8'h40);
    irq_en_i = 0;
  endtask

  task automatic t_enable();
    rx_load_i = 1; rx_data_i = 8'h11; step();
    en_i = 0; step();
    chk("R7 en clr", status_o & 8'hC0, 8'h00);
    tx_xfer_i = 1; step();
    chk("R7 en hold", status_o & 8'h40, 8'h00);
    en_i = 1; drr_rd_i = 1; step();
  endtask

  task automatic t_match();
    ninth_clk_i = 1; byte_is_addr_i = 1; shift_byte_i = {7'h50, 1'b1}; ack_i = 0; step();
    chk("R9 match srw", status_o & 8'h30, 8'h30);
    chk("R13 ack", status_o & 8'h08, 8'h00);
    ninth_clk_i = 1; slave_tx_i = 1; ack_i = 1; step();
    chk("R9 stx keep", status_o & 8'h20, 8'h20);
    chk("R13 nack", status_o & 8'h08, 8'h08);
    ninth_clk_i = 1; step();
    chk("R9 data clr", status_o & 8'h20, 8'h00);
    ninth_clk_i = 1; byte_is_addr_i = 1; shift_byte_i = {7'h55, 1'b0}; step();
    chk("R10 exact only", status_o & 8'h20, 8'h00);
    ext_en_i = 1;
    ninth_clk_i = 1; byte_is_addr_i = 1; shift_byte_i = {7'h55, 1'b0}; step();
    chk("R10 ext hit", status_o & 8'h30, 8'h20);
    ninth_clk_i = 1; byte_is_addr_i = 1; shift_byte_i = {7'h58, 1'b1}; step();
    chk("R10 ext miss", status_o & 8'h30, 8'h00);
    ext_en_i = 0;
  endtask

  task automatic t_crc_mrw();
    pec_done_i = 1; pec_ok_i = 0; step();
    chk("R11 crc set", status_o & 8'h04, 8'h04);
    sr_wr_i = 1; wdata_i = 8'h00; step();
    chk("R11 sr ro", status_o & 8'h04, 8'h04);
    ctrl_wr_i = 1; wdata_i = 8'h01; step();
    chk("R12 mrw set", {7'b0, mrw_o}, 8'h01);
    do_reset();
    chk("R11 crc kept", status_o & 8'h04, 8'h04);
    chk("R12 mrw rst", {7'b0, mrw_o}, 8'h00);
    pec_done_i = 1; pec_ok_i = 1; step();
    chk("R11 crc clr", status_o & 8'h04, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_rx();
    t_tx();
    t_enable();
    t_match();
    t_crc_mrw();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule